// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block turns an asynchronous serial line back into characters. It is stepped by a one-cycle enable, `tick16`, which pulses sixteen times per bit period and comes from the same baud divisor that drives the companion transmitter. The incoming pin passes through a reset-safe synchronizer. The receiver then waits for the line to go low and confirms that low level half a bit later. After that it takes each further bit at its centre. It accepts a character of 5 to 8 data bits, sent least significant bit first, with an optional even or odd parity bit and a stop bit.

The finished character goes into a one-entry receive buffer, which raises a ready flag. Four sticky status flags sit beside the buffer: overrun, parity error, framing error and line break. The host clears the ready flag with a one-cycle buffer-read strobe. It clears the four status flags with a one-cycle status-read strobe. The frame settings are shared with the transmitter and should only change while the line is idle.

Top module: `async_rx16`

## Requirements
- R1: After a synchronous reset, `rx_byte` is 0x00 and `rx_ready`, `err_overrun`, `err_parity`, `err_frame` and `brk_det` are all 0.
- R2: A low level that has ended by the time the line is re-checked is dropped, and no character is produced. The re-check happens 8 ticks after the low level was first seen.
- R3: Data bits arrive least significant bit first. Each one is sampled 16 ticks after the previous sample. The character is loaded and `rx_ready` goes to 1 at the centre of the stop bit, and not before.
- R4: `cfg_wlen` sets the number of data bits: 0 selects 5, 1 selects 6, 2 selects 7 and 3 selects 8. Buffer bits above the selected length read as 0.
- R5: When `cfg_par_en` is 1, one parity bit follows the data. `cfg_par_even` = 1 means data plus parity must hold an even number of ones, and 0 means odd. A mismatch sets `err_parity`.
- R6: Only the first stop bit is checked. If it is sampled low, `err_frame` is set.
- R7: If a character completes while `rx_ready` is still 1 and no buffer read is strobed in that cycle, `err_overrun` is set and the new character replaces the old one.
- R8: If every data bit, the parity bit (when present) and the stop bit are all sampled low, `brk_det` and `err_frame` are set, 0x00 is loaded, `rx_ready` is set, and `err_parity` is left unchanged.
- R9: `buf_rd` clears `rx_ready` on the next edge. `stat_rd` clears the four status flags, but a new error arriving in the same cycle still sets its flag.
- R10: After a stop bit sampled low, no new character starts until the line has been seen high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle enable, 16 per bit period |
| rxd_in | input | 1 | Asynchronous serial input, idle high |
| cfg_wlen | input | 2 | Data length code (5 + code bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| buf_rd | input | 1 | Buffer read strobe, clears ready |
| stat_rd | input | 1 | Status read strobe, clears the four flags |
| rx_byte | output | 8 | Receive buffer |
| rx_ready | output | 1 | Buffer holds an unread character |
| err_overrun | output | 1 | A character was lost to overrun |
| err_parity | output | 1 | Parity mismatch seen |
| err_frame | output | 1 | Stop bit sampled low |
| brk_det | output | 1 | Line break seen |

## Verification
Clean 8-bit characters with alternating and clustered bit patterns expose bit-order and bit-centre errors. Short characters are sent right after a buffer full of ones, which shows whether the upper buffer bits really read as zero. Frames with correct and deliberately wrong parity in both parity senses separate the even and odd checks. A low stop bit after non-zero data is told apart from a long low line, which must give exactly one break character and no phantom second character. A 4-tick low glitch probes the mid-start check, and two unread characters in a row probe overrun.

// File: rtl/arx_pkg.sv
package arx_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_HOLD
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
        logic              brk;
    } rx_char_t;

    // index of the final data bit for a length code (5..8 bits)
    function automatic logic [2:0] last_bit_idx(input logic [1:0] code);
        return {1'b0, code} + 3'd4;
    endfunction

endpackage

// File: rtl/arx_sync.sv
module arx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/arx_framer.sv
module arx_framer
    import arx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       line,
    input  logic [1:0] wlen,
    input  logic       par_en,
    input  logic       par_even,
    output logic       done,
    output rx_char_t   res
);
    localparam int CNT_W = $clog2(OVS);
    localparam logic [CNT_W-1:0] MID_CNT = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] BIT_CNT = CNT_W'(OVS - 1);

    rx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [2:0]        idx;
    logic [DATA_W-1:0] shreg;
    logic              all_low;
    logic              ones_odd;
    logic              par_bad;
    logic              at_centre;
    logic              brk_now;

    assign at_centre = (cnt == BIT_CNT);
    assign brk_now   = all_low & ~line;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            idx      <= '0;
            shreg    <= '0;
            all_low  <= 1'b1;
            ones_odd <= 1'b0;
            par_bad  <= 1'b0;
            done     <= 1'b0;
            res      <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                unique case (state)
                    ST_IDLE: begin
                        if (!line) begin
                            state <= ST_START;
                            cnt   <= '0;
                        end
                    end
                    ST_START: begin
                        if (cnt == MID_CNT) begin
                            cnt <= '0;
                            if (line) begin
                                state <= ST_IDLE;
                            end else begin
                                state    <= ST_DATA;
                                idx      <= '0;
                                shreg    <= '0;
                                all_low  <= 1'b1;
                                ones_odd <= 1'b0;
                                par_bad  <= 1'b0;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (at_centre) begin
                            cnt        <= '0;
                            shreg[idx] <= line;
                            ones_odd   <= ones_odd ^ line;
                            all_low    <= all_low & ~line;
                            if (idx == last_bit_idx(wlen))
                                state <= par_en ? ST_PAR : ST_STOP;
                            else
                                idx <= idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (at_centre) begin
                            cnt     <= '0;
                            par_bad <= ones_odd ^ line ^ ~par_even;
                            all_low <= all_low & ~line;
                            state   <= ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (at_centre) begin
                            cnt      <= '0;
                            done     <= 1'b1;
                            res.data <= shreg;
                            res.ferr <= ~line;
                            res.brk  <= brk_now;
                            res.perr <= par_bad & ~brk_now;
                            state    <= line ? ST_IDLE : ST_HOLD;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_HOLD: begin
                        if (line) state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R3: the state only moves on a tick
    p_state_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(state));

    // R4: bit index never passes the programmed length
    p_idx_in_range_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA) |-> (idx <= last_bit_idx(wlen)));

    // R10: a low line keeps the receiver parked after a low stop bit
    p_hold_low_r10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && tick && !line) |=> (state == ST_HOLD));

    // R2: a start that is high at the mid-bit check never reaches data
    p_false_start_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_START && tick && cnt == MID_CNT && line) |=> (state == ST_IDLE));
endmodule

// File: rtl/arx_status.sv
module arx_status
    import arx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  rx_char_t          res,
    input  logic              buf_rd,
    input  logic              stat_rd,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_ready,
    output logic              err_overrun,
    output logic              err_parity,
    output logic              err_frame,
    output logic              brk_det
);
    logic ovr_n, pe_n, fe_n, bi_n;

    always_comb begin
        ovr_n = err_overrun & ~stat_rd;
        pe_n  = err_parity  & ~stat_rd;
        fe_n  = err_frame   & ~stat_rd;
        bi_n  = brk_det     & ~stat_rd;
        if (done) begin
            ovr_n = ovr_n | (rx_ready & ~buf_rd);
            pe_n  = pe_n | res.perr;
            fe_n  = fe_n | res.ferr;
            bi_n  = bi_n | res.brk;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_byte     <= '0;
            rx_ready    <= 1'b0;
            err_overrun <= 1'b0;
            err_parity  <= 1'b0;
            err_frame   <= 1'b0;
            brk_det     <= 1'b0;
        end else begin
            err_overrun <= ovr_n;
            err_parity  <= pe_n;
            err_frame   <= fe_n;
            brk_det     <= bi_n;
            if (done) begin
                rx_byte  <= res.data;
                rx_ready <= 1'b1;
            end else if (buf_rd) begin
                rx_ready <= 1'b0;
            end
        end
    end

    // R9: a buffer read with no arrival empties the buffer
    p_read_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (buf_rd && !done) |=> !rx_ready);

    // R8: a break always comes with a zero byte and a framing error
    p_break_zero_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(brk_det) |-> (rx_byte == '0 && err_frame && rx_ready));

    // R7: overrun only appears alongside a held character
    p_overrun_ready_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(err_overrun) |-> rx_ready);
endmodule

// File: rtl/async_rx16.sv
module async_rx16
    import arx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick16,
    input  logic              rxd_in,
    input  logic [1:0]        cfg_wlen,
    input  logic              cfg_par_en,
    input  logic              cfg_par_even,
    input  logic              buf_rd,
    input  logic              stat_rd,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_ready,
    output logic              err_overrun,
    output logic              err_parity,
    output logic              err_frame,
    output logic              brk_det
);
    logic     line_s;
    logic     done;
    rx_char_t res;

    arx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rxd_in),
        .dout (line_s)
    );

    arx_framer #(.OVS(OVS)) u_framer (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick16),
        .line     (line_s),
        .wlen     (cfg_wlen),
        .par_en   (cfg_par_en),
        .par_even (cfg_par_even),
        .done     (done),
        .res      (res)
    );

    arx_status u_status (
        .clk         (clk),
        .rst         (rst),
        .done        (done),
        .res         (res),
        .buf_rd      (buf_rd),
        .stat_rd     (stat_rd),
        .rx_byte     (rx_byte),
        .rx_ready    (rx_ready),
        .err_overrun (err_overrun),
        .err_parity  (err_parity),
        .err_frame   (err_frame),
        .brk_det     (brk_det)
    );

    // R4: a freshly loaded byte has nothing above the programmed length
    p_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_ready) |-> ((rx_byte >> (last_bit_idx(cfg_wlen) + 1)) == '0));
endmodule

// File: tb/tb_async_rx16.sv
module tb_async_rx16;
    localparam int OVS     = 16;
    localparam int BIT_CLK = OVS * 2;

    logic       clk = 1'b0;
    logic       rst, tick16, rxd_in, cfg_par_en, cfg_par_even, buf_rd, stat_rd;
    logic [1:0] cfg_wlen;
    logic [7:0] rx_byte;
    logic       rx_ready, err_overrun, err_parity, err_frame, brk_det;

    int checks = 0;
    int fails  = 0;
    bit cmp_en = 0;
    bit done_flag = 0;

    logic [7:0] m_byte;
    bit m_ready, m_ovr, m_pe, m_fe, m_bi;

    always #4 clk = ~clk;

    async_rx16 #(.OVS(OVS)) dut (
        .clk(clk), .rst(rst), .tick16(tick16), .rxd_in(rxd_in),
        .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
        .buf_rd(buf_rd), .stat_rd(stat_rd), .rx_byte(rx_byte), .rx_ready(rx_ready),
        .err_overrun(err_overrun), .err_parity(err_parity), .err_frame(err_frame),
        .brk_det(brk_det)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one clock: compare against the model, then advance the tick phase
    task automatic step();
        @(negedge clk);
        if (cmp_en) begin
            check("R3 byte",     rx_byte,     m_byte);
            check("R3 ready",    rx_ready,    m_ready);
            check("R7 overrun",  err_overrun, m_ovr);
            check("R5 parity",   err_parity,  m_pe);
            check("R6 frame",    err_frame,   m_fe);
            check("R8 break",    brk_det,     m_bi);
        end
        tick16 = ~tick16;
    endtask

    task automatic wait_bits(input int n);
        repeat (n * BIT_CLK) step();
    endtask

    task automatic rd_buf();
        buf_rd = 1'b1; m_ready = 0;
        step();
        buf_rd = 1'b0;
    endtask

    task automatic rd_stat();
        stat_rd = 1'b1; m_ovr = 0; m_pe = 0; m_fe = 0; m_bi = 0;
        step();
        stat_rd = 1'b0;
    endtask

    task automatic send(input logic [7:0] data, input int nb, input bit pen,
                        input bit peven, input bit badpar, input bit stopv);
        logic [7:0] md;
        bit pbit, brk;
        md = data & 8'((1 << nb) - 1);
        pbit = peven ? ^md : ~^md;
        if (badpar) pbit = ~pbit;
        rxd_in = 1'b0; wait_bits(1);
        for (int i = 0; i < nb; i++) begin
            rxd_in = md[i]; wait_bits(1);
        end
        if (pen) begin
            rxd_in = pbit; wait_bits(1);
        end
        // R3: nothing may arrive before the stop bit centre
        check("R3 not early", rx_ready, m_ready);
        cmp_en = 0;
        rxd_in = stopv; wait_bits(1);
        rxd_in = 1'b1;
        brk = (md == 0) && !stopv && (!pen || !pbit);
        if (m_ready) m_ovr = 1;
        m_byte = brk ? 8'h00 : md;
        m_ready = 1;
        if (pen && badpar && !brk) m_pe = 1;
        if (!stopv) m_fe = 1;
        if (brk) m_bi = 1;
        cmp_en = 1;
        wait_bits(2);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done_flag) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1; tick16 = 0; rxd_in = 1; cfg_wlen = 2'd3; cfg_par_en = 0;
        cfg_par_even = 1; buf_rd = 0; stat_rd = 0;
        m_byte = 0; m_ready = 0; m_ovr = 0; m_pe = 0; m_fe = 0; m_bi = 0;
        repeat (6) step();
        rst = 0;
        step();
        // R1 reset state
        check("R1 byte", rx_byte, 0);
        check("R1 ready", rx_ready, 0);
        check("R1 flags", {err_overrun, err_parity, err_frame, brk_det}, 0);
        cmp_en = 1;

        // R3 plain 8-bit characters
        send(8'hA5, 8, 0, 0, 0, 1);
        check("R3 A5", rx_byte, 8'hA5);
        rd_buf();
        check("R9 ready cleared", rx_ready, 0);
        send(8'h3C, 8, 0, 0, 0, 1); rd_buf();
        send(8'hC3, 8, 0, 0, 0, 1);
        check("R3 C3", rx_byte, 8'hC3);
        rd_buf();

        // R4 short words after a buffer of ones
        send(8'hFF, 8, 0, 0, 0, 1); rd_buf();
        cfg_wlen = 2'd0; step();
        send(8'hF5, 5, 0, 0, 0, 1);
        check("R4 five bits", rx_byte, 8'h15);
        rd_buf();
        cfg_wlen = 2'd1; step();
        send(8'hEA, 6, 0, 0, 0, 1);
        check("R4 six bits", rx_byte, 8'h2A);
        rd_buf();
        cfg_wlen = 2'd2; step();
        send(8'hD5, 7, 0, 0, 0, 1);
        check("R4 seven bits", rx_byte, 8'h55);
        rd_buf();
        cfg_wlen = 2'd3;

        // R5 parity in both senses
        cfg_par_en = 1; cfg_par_even = 1; step();
        send(8'h07, 8, 1, 1, 0, 1);
        check("R5 even good", err_parity, 0);
        rd_buf();
        send(8'h07, 8, 1, 1, 1, 1);
        check("R5 even bad", err_parity, 1);
        rd_buf(); rd_stat();
        check("R9 status cleared", err_parity, 0);
        cfg_par_even = 0; step();
        send(8'h07, 8, 1, 0, 0, 1);
        check("R5 odd good", err_parity, 0);
        rd_buf();
        send(8'h5A, 8, 1, 0, 1, 1);
        check("R5 odd bad", err_parity, 1);
        rd_buf(); rd_stat();
        cfg_par_en = 0; step();

        // R6 low stop bit with non-zero data
        send(8'h81, 8, 0, 0, 0, 0);
        check("R6 frame", err_frame, 1);
        check("R6 no break", brk_det, 0);
        rd_buf(); rd_stat();

        // R7 overrun
        send(8'h11, 8, 0, 0, 0, 1);
        send(8'h22, 8, 0, 0, 0, 1);
        check("R7 overrun", err_overrun, 1);
        check("R7 newest kept", rx_byte, 8'h22);
        rd_buf(); rd_stat();

        // R2 short glitch
        rxd_in = 0; repeat (8) step();
        rxd_in = 1; wait_bits(3);
        check("R2 glitch ignored", rx_ready, 0);

        // R8 and R10 long break
        cmp_en = 0;
        rxd_in = 0; wait_bits(14);
        rxd_in = 1; wait_bits(12);
        m_byte = 0; m_ready = 1; m_fe = 1; m_bi = 1;
        check("R8 break", brk_det, 1);
        check("R8 frame", err_frame, 1);
        check("R8 zero byte", rx_byte, 0);
        check("R10 single char", err_overrun, 0);
        cmp_en = 1;
        rd_buf(); rd_stat();

        // recovery after break
        send(8'h96, 8, 0, 0, 0, 1);
        check("R3 after break", rx_byte, 8'h96);
        rd_buf();
        wait_bits(1);

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule